// File: doc/BRIEF.md
# Sliding Reference Window Buffer

This block holds the reference-frame search window used by a full-search motion estimator with a ±16 pixel range. The window is 48 pixels wide and 48 rows tall. It is kept as three column strips, each 16 pixels wide. Consecutive macroblocks in a row are processed left to right, so their windows overlap by 32 columns. For each new macroblock the block therefore fetches only the one strip that has newly come into view. It writes that strip over the strip that has just left the window. A strip pointer turns the three physical strips into a ring, so data that stays in the window is never moved.

A macroblock request with the row-start flag set, or any request while no window has yet been filled, triggers a full reload of all three strips. Any other request replaces one strip (768 bytes). Reference data arrives as 32-bit words, each holding four pixels, through a valid/ready stream. A pixel read port takes window-relative column and row coordinates and returns one pixel a cycle later. It holds its ready low for any pixel whose strip is still being written.

Top module: `search_window_buf`

## Requirements
- R1: After reset, mb_ready is 1, and win_ready, ld_ready, rd_ready and rd_rvalid are 0.
- R2: A request accepted with mb_first=1 starts a full reload of 576 words. mb_ready stays low and win_ready stays 0 until the 576th word is accepted. In the cycle after that word, win_ready and mb_ready are 1.
- R3: In a full reload, stream word k (0..575) fills window strip k/192, which covers columns 16*(k/192) to 16*(k/192)+15. With j = k mod 192, the word lands in row j/4. Bits [8b+7:8b] of the word become the pixel at column 16*(k/192) + 4*(j mod 4) + b.
- R4: A request with mb_first=0 on a filled window takes exactly 192 words and slides the window 16 columns to the right. New columns 0..31 hold the old columns 16..47. Word j of the new strip fills row j/4, and its byte b lands at column 32 + 4*(j mod 4) + b.
- R5: While a single strip is being replaced, reads of columns 0..31 are accepted (rd_ready=1). Reads of columns 32..47 are refused (rd_ready=0).
- R6: During a full reload, rd_ready is 0 for every coordinate.
- R7: An accepted read (rd_valid and rd_ready both 1 at a clock edge) raises rd_rvalid for exactly the following cycle, with the addressed pixel on rd_data. A refused read produces no rd_rvalid.
- R8: A read with column ≥ 48 or row ≥ 48 has rd_ready=0.
- R9: ld_ready is 0 whenever no load is in progress. Words offered on the load stream while idle are ignored and leave the window unchanged.
- R10: A request with mb_first=1 in the middle of a row discards the current window and reloads all three strips in the R3 order.
- R11: Idle cycles between load words (ld_valid low) neither drop words nor reorder them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_valid | input | 1 | New macroblock request |
| mb_first | input | 1 | Request is the first macroblock of a row (full reload) |
| mb_ready | output | 1 | Sequencer idle, request can be taken |
| ld_valid | input | 1 | Load word present |
| ld_data | input | 32 | Four reference pixels, lowest column in the low byte |
| ld_ready | output | 1 | Load word accepted at this edge |
| rd_valid | input | 1 | Pixel read request |
| rd_col | input | 6 | Window-relative column, 0..47 |
| rd_row | input | 6 | Window-relative row, 0..47 |
| rd_ready | output | 1 | Read can be accepted |
| rd_rvalid | output | 1 | Read data valid |
| rd_data | output | 8 | Pixel read result |
| win_ready | output | 1 | Whole window valid and no load running |

## Verification
A read accepted at a clock edge has its pixel due on rd_data at the very next edge. A load word accepted at an edge is readable from the edge after it. win_ready and mb_ready change in the cycle after the last word of a load. The bench drives on the falling edge, samples ready signals just after driving, and samples results on the following falling edge. The scoreboard keeps the cycle number in which each read was accepted. The monitor pops an entry only when rd_rvalid is high, and it flags any result that comes at a cycle other than acceptance plus one, as well as any result with no matching entry.

// File: rtl/swb_pkg.sv
// Package for the sliding reference window buffer.
// Holds the sequencer state type shared by the load sequencer and its checks.
package swb_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_LOAD = 1'b1
    } swb_state_e;

endpackage

// File: rtl/swb_load_seq.sv
// Load sequencer: accepts macroblock requests, then counts load words into
// strips of the window store, rotating the strip ring pointer.
// Assumes N_STRIPS >= 2 and that the upstream sends words in strip order.
module swb_load_seq
    import swb_pkg::*;
#(
    parameter int N_STRIPS    = 3,
    parameter int STRIP_WORDS = 192,
    parameter int DATA_W      = 32,
    parameter int SP_W        = $clog2(N_STRIPS),
    parameter int WC_W        = $clog2(STRIP_WORDS),
    parameter int ADDR_W      = $clog2(STRIP_WORDS * N_STRIPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mb_valid,
    input  logic              mb_first,
    output logic              mb_ready,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    output logic              ld_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [SP_W-1:0]   base,
    output logic [SP_W-1:0]   wr_strip,
    output logic              loading,
    output logic              full_mode,
    output logic              win_valid
);

    swb_state_e      state_q;
    logic [SP_W-1:0] base_q;
    logic [SP_W-1:0] wr_strip_q;
    logic [SP_W-1:0] left_q;
    logic [WC_W-1:0] word_q;
    logic            full_q;
    logic            valid_q;

    logic mb_fire;
    logic ld_fire;
    logic last_word;
    logic need_full;

    // Next strip index around the ring.
    function automatic logic [SP_W-1:0] next_strip(input logic [SP_W-1:0] p);
        return (p == SP_W'(N_STRIPS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Handshake decode for the request and load streams.
    always_comb begin
        mb_fire   = mb_valid && (state_q == SEQ_IDLE);
        ld_fire   = ld_valid && (state_q == SEQ_LOAD);
        last_word = (word_q == WC_W'(STRIP_WORDS - 1));
        need_full = mb_first || !valid_q;
    end

    // Sequencer state, strip ring pointer and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            base_q     <= '0;
            wr_strip_q <= '0;
            left_q     <= '0;
            word_q     <= '0;
            full_q     <= 1'b0;
            valid_q    <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (mb_fire) begin
                        state_q <= SEQ_LOAD;
                        word_q  <= '0;
                        if (need_full) begin
                            base_q     <= '0;
                            wr_strip_q <= '0;
                            left_q     <= SP_W'(N_STRIPS - 1);
                            full_q     <= 1'b1;
                            valid_q    <= 1'b0;
                        end else begin
                            wr_strip_q <= base_q;
                            base_q     <= next_strip(base_q);
                            left_q     <= '0;
                            full_q     <= 1'b0;
                        end
                    end
                end
                SEQ_LOAD: begin
                    if (ld_fire) begin
                        if (!last_word) begin
                            word_q <= word_q + 1'b1;
                        end else if (left_q == '0) begin
                            state_q <= SEQ_IDLE;
                            valid_q <= 1'b1;
                            full_q  <= 1'b0;
                            word_q  <= '0;
                        end else begin
                            wr_strip_q <= next_strip(wr_strip_q);
                            left_q     <= left_q - 1'b1;
                            word_q     <= '0;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Drive the store write port and status outputs.
    always_comb begin
        mb_ready  = (state_q == SEQ_IDLE);
        ld_ready  = (state_q == SEQ_LOAD);
        wr_en     = ld_fire;
        wr_addr   = ADDR_W'(wr_strip_q) * ADDR_W'(STRIP_WORDS) + ADDR_W'(word_q);
        wr_data   = ld_data;
        base      = base_q;
        wr_strip  = wr_strip_q;
        loading   = (state_q == SEQ_LOAD);
        full_mode = full_q;
        win_valid = valid_q;
    end

    // A taken request always leaves the sequencer busy for at least one cycle.
    assert_busy_after_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && mb_ready) |=> !mb_ready);

    // A single-strip request steps the ring base by one position.
    assert_base_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && mb_ready && !mb_first && win_valid) |=> (base == next_strip($past(base))));

    // A row-start request rewinds the ring base to strip zero.
    assert_row_start_rewinds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && mb_ready && mb_first) |=> (base == '0 && !win_valid));

    // The window only becomes valid straight after an accepted load word.
    assert_valid_after_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid) |-> $past(ld_valid && ld_ready));

endmodule

// File: rtl/swb_strip_map.sv
// Read address translation: window-relative column/row to physical store
// word address and byte lane, through the strip ring base pointer.
// Assumes STRIP_W is a multiple of PIX_PER_WORD.
module swb_strip_map #(
    parameter int N_STRIPS     = 3,
    parameter int STRIP_W      = 16,
    parameter int WIN_H        = 48,
    parameter int PIX_PER_WORD = 4,
    parameter int SP_W         = $clog2(N_STRIPS),
    parameter int COL_W        = $clog2(N_STRIPS * STRIP_W),
    parameter int ROW_W        = $clog2(WIN_H),
    parameter int ADDR_W       = $clog2(N_STRIPS * STRIP_W * WIN_H / PIX_PER_WORD),
    parameter int LANE_W       = $clog2(PIX_PER_WORD)
) (
    input  logic [SP_W-1:0]   base,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [SP_W-1:0]   phys,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] lane,
    output logic              in_range
);

    localparam int WIN_W         = N_STRIPS * STRIP_W;
    localparam int WORDS_PER_ROW = STRIP_W / PIX_PER_WORD;
    localparam int STRIP_WORDS   = WORDS_PER_ROW * WIN_H;

    logic [COL_W-1:0] strip_off;
    logic [COL_W-1:0] col_in_strip;
    logic [COL_W:0]   ring_sum;

    // Split the column into strip offset and in-strip position, then wrap.
    always_comb begin
        strip_off    = rd_col / COL_W'(STRIP_W);
        col_in_strip = rd_col % COL_W'(STRIP_W);
        ring_sum     = (COL_W+1)'(base) + (COL_W+1)'(strip_off);
        phys         = (ring_sum >= (COL_W+1)'(N_STRIPS))
                       ? SP_W'(ring_sum - (COL_W+1)'(N_STRIPS))
                       : SP_W'(ring_sum);
        rd_addr      = ADDR_W'(phys) * ADDR_W'(STRIP_WORDS)
                     + ADDR_W'(rd_row) * ADDR_W'(WORDS_PER_ROW)
                     + ADDR_W'(col_in_strip / COL_W'(PIX_PER_WORD));
        lane         = LANE_W'(rd_col % COL_W'(PIX_PER_WORD));
        in_range     = ({1'b0, rd_col} < (COL_W+1)'(WIN_W))
                    && ({1'b0, rd_row} < (ROW_W+1)'(WIN_H));
    end

endmodule

// File: rtl/swb_store.sv
// Window store: one word-wide memory, one write port and one registered
// read port with byte-lane selection on the output.
// Assumes the caller only enables reads at in-range addresses.
module swb_store #(
    parameter int DEPTH        = 576,
    parameter int PIX_W        = 8,
    parameter int PIX_PER_WORD = 4,
    parameter int DATA_W       = PIX_W * PIX_PER_WORD,
    parameter int ADDR_W       = $clog2(DEPTH),
    parameter int LANE_W       = $clog2(PIX_PER_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LANE_W-1:0] rd_lane,
    output logic              rd_rvalid,
    output logic [PIX_W-1:0]  rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic              rvalid_q;
    logic [PIX_W-1:0]  lanes [PIX_PER_WORD];

    // Memory write and registered word read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            word_q <= mem[rd_addr];
            lane_q <= rd_lane;
        end
    end

    // Read-valid flag, one cycle behind the accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
        end
    end

    // Split the read word into pixel lanes.
    for (genvar g = 0; g < PIX_PER_WORD; g++) begin : g_lane
        assign lanes[g] = word_q[g*PIX_W +: PIX_W];
    end

    assign rd_rvalid = rvalid_q;
    assign rd_data   = lanes[lane_q];

    // Result valid only in the cycle after an enabled read.
    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rvalid |-> $past(rd_en));

endmodule

// File: rtl/search_window_buf.sv
// Sliding reference window buffer, top level.
// Ties the load sequencer, read address map and window store together and
// decides which reads may be accepted while a load is running.
// Assumes raster-order macroblocks; row-start requests carry mb_first.
module search_window_buf #(
    parameter int N_STRIPS     = 3,
    parameter int STRIP_W      = 16,
    parameter int WIN_H        = 48,
    parameter int PIX_W        = 8,
    parameter int PIX_PER_WORD = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    mb_valid,
    input  logic                                    mb_first,
    output logic                                    mb_ready,
    input  logic                                    ld_valid,
    input  logic [PIX_W*PIX_PER_WORD-1:0]           ld_data,
    output logic                                    ld_ready,
    input  logic                                    rd_valid,
    input  logic [$clog2(N_STRIPS*STRIP_W)-1:0]     rd_col,
    input  logic [$clog2(WIN_H)-1:0]                rd_row,
    output logic                                    rd_ready,
    output logic                                    rd_rvalid,
    output logic [PIX_W-1:0]                        rd_data,
    output logic                                    win_ready
);

    localparam int WIN_W         = N_STRIPS * STRIP_W;
    localparam int WORDS_PER_ROW = STRIP_W / PIX_PER_WORD;
    localparam int STRIP_WORDS   = WORDS_PER_ROW * WIN_H;
    localparam int DEPTH         = STRIP_WORDS * N_STRIPS;
    localparam int DATA_W        = PIX_W * PIX_PER_WORD;
    localparam int ADDR_W        = $clog2(DEPTH);
    localparam int SP_W          = $clog2(N_STRIPS);
    localparam int WC_W          = $clog2(STRIP_WORDS);
    localparam int COL_W         = $clog2(WIN_W);
    localparam int ROW_W         = $clog2(WIN_H);
    localparam int LANE_W        = $clog2(PIX_PER_WORD);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [SP_W-1:0]   base;
    logic [SP_W-1:0]   wr_strip;
    logic              loading;
    logic              full_mode;
    logic              win_valid;
    logic [SP_W-1:0]   phys;
    logic [ADDR_W-1:0] rd_addr;
    logic [LANE_W-1:0] lane;
    logic              in_range;
    logic              rd_en;

    swb_load_seq #(
        .N_STRIPS    (N_STRIPS),
        .STRIP_WORDS (STRIP_WORDS),
        .DATA_W      (DATA_W),
        .SP_W        (SP_W),
        .WC_W        (WC_W),
        .ADDR_W      (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mb_valid  (mb_valid),
        .mb_first  (mb_first),
        .mb_ready  (mb_ready),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .ld_ready  (ld_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .base      (base),
        .wr_strip  (wr_strip),
        .loading   (loading),
        .full_mode (full_mode),
        .win_valid (win_valid)
    );

    swb_strip_map #(
        .N_STRIPS     (N_STRIPS),
        .STRIP_W      (STRIP_W),
        .WIN_H        (WIN_H),
        .PIX_PER_WORD (PIX_PER_WORD),
        .SP_W         (SP_W),
        .COL_W        (COL_W),
        .ROW_W        (ROW_W),
        .ADDR_W       (ADDR_W),
        .LANE_W       (LANE_W)
    ) u_map (
        .base     (base),
        .rd_col   (rd_col),
        .rd_row   (rd_row),
        .phys     (phys),
        .rd_addr  (rd_addr),
        .lane     (lane),
        .in_range (in_range)
    );

    swb_store #(
        .DEPTH        (DEPTH),
        .PIX_W        (PIX_W),
        .PIX_PER_WORD (PIX_PER_WORD),
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .LANE_W       (LANE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_lane   (lane),
        .rd_rvalid (rd_rvalid),
        .rd_data   (rd_data)
    );

    // Read gating: window filled, coordinate in range, strip not under write.
    always_comb begin
        rd_ready  = win_valid && in_range
                 && !(loading && (full_mode || (phys == wr_strip)));
        rd_en     = rd_valid && rd_ready;
        win_ready = win_valid && !loading;
    end

    // An accepted read never touches the strip the sequencer is writing.
    assert_no_read_of_written_strip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && loading) |-> (phys != wr_strip));

    // Nothing is readable while all strips are being reloaded.
    assert_full_reload_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && full_mode) |-> !rd_ready);

    // Accepted reads are always inside the window.
    assert_read_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ({1'b0, rd_col} < (COL_W+1)'(WIN_W) && {1'b0, rd_row} < (ROW_W+1)'(WIN_H)));

    // Load words are only taken while the request side is busy.
    assert_load_only_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |-> !mb_ready);

endmodule

// File: tb/search_window_buf_bench.sv
// Scoreboard bench for the sliding reference window buffer.
module search_window_buf_bench;

    localparam int W     = 48;
    localparam int SW    = 192;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mb_valid = 1'b0;
    logic        mb_first = 1'b0;
    logic        mb_ready;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_data = '0;
    logic        ld_ready;
    logic        rd_valid = 1'b0;
    logic [5:0]  rd_col = '0;
    logic [5:0]  rd_row = '0;
    logic        rd_ready;
    logic        rd_rvalid;
    logic [7:0]  rd_data;
    logic        win_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] model [W*W];
    logic [7:0] exp_q [$];
    int         due_q [$];

    search_window_buf u_search_window_buf (
        .clk (clk), .rst_n (rst_n),
        .mb_valid (mb_valid), .mb_first (mb_first), .mb_ready (mb_ready),
        .ld_valid (ld_valid), .ld_data (ld_data), .ld_ready (ld_ready),
        .rd_valid (rd_valid), .rd_col (rd_col), .rd_row (rd_row),
        .rd_ready (rd_ready), .rd_rvalid (rd_rvalid), .rd_data (rd_data),
        .win_ready (win_ready)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] pix(input int tag, input int k, input int b);
        return 8'((k*4 + b)*7 + (k >> 6)*13 + tag*53);
    endfunction

    function automatic logic [31:0] word_of(input int tag, input int k);
        logic [31:0] w;
        for (int b = 0; b < 4; b++) w[8*b +: 8] = pix(tag, k, b);
        return w;
    endfunction

    // Monitor: pop the scoreboard on every returned pixel.
    always @(negedge clk) begin
        if (rst_n && rd_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected rd_rvalid", 1, 0);
            end else begin
                logic [7:0] e;
                int d;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                check(rd_data == e, "R3/R4 pixel value", rd_data, e);
                check(cyc == d, "R7 return cycle", cyc, d);
            end
        end
    end

    // Driver pieces; each is entered and left on a falling edge.
    task automatic start_mb(input bit first);
        mb_valid = 1'b1;
        mb_first = first;
        #1;
        while (!mb_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        mb_valid = 1'b0;
        mb_first = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] d);
        ld_valid = 1'b1;
        ld_data  = d;
        #1;
        while (!ld_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic do_read(input int col, input int row, input bit exp_rdy, input string req);
        rd_valid = 1'b1;
        rd_col   = 6'(col);
        rd_row   = 6'(row);
        #1;
        check(rd_ready == exp_rdy, req, rd_ready, exp_rdy);
        if (rd_ready) begin
            exp_q.push_back(model[row*W + col]);
            due_q.push_back(cyc + 1);
        end
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic verify_all();
        for (int r = 0; r < W; r++)
            for (int c = 0; c < W; c++)
                do_read(c, r, 1'b1, "R3/R4 window read ready");
    endtask

    task automatic full_load(input int tag, input int gap);
        start_mb(1'b1);
        rd_col = 6'd0; rd_row = 6'd0; #1;
        check(rd_ready == 1'b0, "R6 read blocked in full reload", rd_ready, 0);
        for (int k = 0; k < 3*SW; k++) begin
            if (k == 3*SW - 1) begin
                #1;
                check(win_ready == 1'b0, "R2 win_ready low before last word", win_ready, 0);
                check(mb_ready == 1'b0, "R2 mb_ready low during load", mb_ready, 0);
            end
            send_word(word_of(tag, k));
            if (gap != 0 && (k % gap) == 0) @(negedge clk);   // R11 bubbles
        end
        #1;
        check(win_ready == 1'b1, "R2 win_ready after last word", win_ready, 1);
        check(mb_ready == 1'b1, "R2 mb_ready after last word", mb_ready, 1);
        for (int k = 0; k < 3*SW; k++)
            for (int b = 0; b < 4; b++)
                model[((k % SW)/4)*W + (k/SW)*16 + ((k % SW) % 4)*4 + b] = pix(tag, k, b);
    endtask

    task automatic step_load(input int tag);
        start_mb(1'b0);
        for (int r = 0; r < W; r++)
            for (int c = 0; c < 32; c++)
                model[r*W + c] = model[r*W + c + 16];
        do_read(5, 7, 1'b1, "R5 old strip readable during replace");
        do_read(40, 7, 1'b0, "R5 replaced strip blocked");
        for (int k = 0; k < 100; k++) send_word(word_of(tag, k));
        do_read(20, 30, 1'b1, "R5 old strip readable mid replace");
        do_read(47, 0, 1'b0, "R5 replaced strip blocked mid replace");
        for (int k = 100; k < SW; k++) send_word(word_of(tag, k));
        #1;
        check(mb_ready == 1'b1, "R4 idle after 192 words", mb_ready, 1);
        check(ld_ready == 1'b0, "R4 no further words taken", ld_ready, 0);
        for (int k = 0; k < SW; k++)
            for (int b = 0; b < 4; b++)
                model[(k/4)*W + 32 + (k % 4)*4 + b] = pix(tag, k, b);
    endtask

    initial begin
        #(LIMIT * 5);
        check(1'b0, "watchdog expired", cyc, LIMIT);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(mb_ready == 1'b1, "R1 mb_ready in reset", mb_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(mb_ready == 1'b1, "R1 mb_ready after reset", mb_ready, 1);
        check(win_ready == 1'b0, "R1 win_ready after reset", win_ready, 0);
        check(ld_ready == 1'b0, "R1 ld_ready after reset", ld_ready, 0);
        check(rd_ready == 1'b0, "R1 rd_ready after reset", rd_ready, 0);
        check(rd_rvalid == 1'b0, "R1 rd_rvalid after reset", rd_rvalid, 0);
        @(negedge clk);

        full_load(1, 7);          // R2, R3, R11
        verify_all();
        step_load(2);             // R4, R5
        verify_all();
        step_load(3);
        step_load(4);
        verify_all();

        do_read(48, 0, 1'b0, "R8 column out of window");
        do_read(0, 48, 1'b0, "R8 row out of window");
        do_read(47, 47, 1'b1, "R8 last in-window pixel");

        ld_valid = 1'b1;          // R9: words while idle are ignored
        ld_data  = 32'hdead_beef;
        for (int i = 0; i < 5; i++) begin
            #1;
            check(ld_ready == 1'b0, "R9 ld_ready idle", ld_ready, 0);
            @(negedge clk);
        end
        ld_valid = 1'b0;
        for (int c = 0; c < W; c += 5) do_read(c, c % 48, 1'b1, "R9 window unchanged");

        full_load(9, 0);          // R10 mid-row restart
        verify_all();
        step_load(10);
        verify_all();

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
        summary();
    end

endmodule